// File: doc/BRIEF.md
# AM Envelope Slicer

This block turns a stream of 8-bit signed samples of an amplitude-modulated carrier into one serial data bit. The carrier is assumed to be band-limited already. Each sample whose valid strobe is high is rectified to a magnitude. The magnitude then enters an eight-deep running-sum window, and the window average (the sum shifted right by three) is compared with a programmable decision level. When the average lies strictly above that level, the bit is 1.

The decision level lives in one register behind a Wishbone classic slave port, so a microcontroller can set it and read it back. The averaging window spans a small fraction of one symbol at the intended 10, 40 and 80 kbit/s rates on a clock of 100 MHz or more. For that reason the block contains no rate-dependent logic. Bit timing recovery is left to whatever consumes the serial output.

Top module: `am_env_slicer`

## Requirements
- R1: After synchronous reset, `bit_out` and `bit_valid` are 0, every window entry and the running sum are 0, and the threshold register reads back 0x40.
- R2: Input samples are two's complement. The magnitude entering the window is the absolute value, with -128 (0x80) saturated to 127.
- R3: The running sum equals the sum of the last eight accepted magnitudes and never exceeds 8 x 127. The average is that sum shifted right by 3, rounding down.
- R4: On the clock edge that accepts a sample, `bit_out` becomes 1 if the updated average is strictly greater than the threshold held before that edge, otherwise 0.
- R5: While `samp_valid` is low, the sample is ignored: the window does not change and `bit_out` and `bit_valid` hold their values.
- R6: `bit_valid` rises on the edge that accepts the first sample after reset and stays 1 until the next reset.
- R7: `wb_ack_o` is high for exactly one cycle, on the clock after a cycle where `wb_cyc_i` and `wb_stb_i` are both high and no ack was pending.
- R8: A write to word offset 0 with `wb_sel_i[0]` set loads `wb_dat_i[7:0]` into the threshold. A write with `wb_sel_i[0]` clear leaves it unchanged. A read of offset 0 returns the threshold zero-extended on `wb_dat_o` while ack is high.
- R9: An access to any nonzero offset is acknowledged, leaves the threshold unchanged, and reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_valid | input | 1 | Sample on `samp_data` is taken this cycle |
| samp_data | input | 8 | Signed two's-complement sample |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | 4 | Word offset; only 0 is decoded |
| wb_sel_i | input | 4 | Byte selects; only bit 0 matters |
| wb_dat_i | input | 32 | Write data; bits 7:0 carry the threshold |
| wb_dat_o | output | 32 | Read data, valid while ack is high |
| wb_ack_o | output | 1 | Single-cycle acknowledge |
| bit_out | output | 1 | Decided serial data bit |
| bit_valid | output | 1 | A sample has been decided since reset |

## Verification
The assertions assume the bus master follows classic single-cycle handshakes: it keeps `wb_cyc_i` and `wb_stb_i` high until it sees the ack, and drops them in the cycle that follows. They also assume that every input is known, without X, outside reset. The stimulus tasks raise a request for exactly one clock, release it after the ack, and drive every input from a defined value at the falling edge. Random envelope traffic with gaps in `samp_valid` is mixed with threshold writes issued mid-stream, so the check that the threshold is sampled before its write is exercised on live data.

// File: rtl/am_slicer_pkg.sv
package am_slicer_pkg;

   // Decoded view of one bus request
   typedef struct packed {
      logic take;   // request accepted this cycle
      logic hit;    // the request addresses the threshold word
      logic write;  // threshold is loaded this cycle
   } bus_req_t;

   // Largest magnitude the rectifier can emit for a given sample width
   function automatic int unsigned max_mag(int unsigned w, bit signed_in);
      return signed_in ? ((2 ** (w - 1)) - 1) : ((2 ** w) - 1);
   endfunction

endpackage

// File: rtl/am_rectify.sv
module am_rectify #(
   parameter int W         = 8,
   parameter bit SIGNED_IN = 1'b1
) (
   input  logic [W-1:0] raw,
   output logic [W-1:0] mag
);

   generate
      if (SIGNED_IN) begin : g_signed
         localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
         localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
         localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};
         always_comb begin
            if (raw == MOST_NEG)
               mag = MOST_POS;            // saturate the one value with no positive twin
            else if (raw[W-1])
               mag = (~raw) + ONE;
            else
               mag = raw;
         end
      end else begin : g_unsigned
         assign mag = raw;
      end
   endgenerate

endmodule

// File: rtl/am_window_avg.sv
module am_window_avg #(
   parameter int W        = 8,
   parameter int LOG2_LEN = 3
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  push,
   input  logic [W-1:0]          din,
   output logic [W+LOG2_LEN-1:0] sum_q,
   output logic [W+LOG2_LEN-1:0] sum_d
);

   localparam int LEN   = 1 << LOG2_LEN;
   localparam int SUM_W = W + LOG2_LEN;

   logic [W-1:0] tap [LEN];

   // Add the newcomer and drop the sample falling off the far end
   assign sum_d = sum_q
                + {{LOG2_LEN{1'b0}}, din}
                - {{LOG2_LEN{1'b0}}, tap[LEN-1]};

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < LEN; i++) tap[i] <= '0;
         sum_q <= '0;
      end else if (push) begin
         tap[0] <= din;
         for (int i = 1; i < LEN; i++) tap[i] <= tap[i-1];
         sum_q <= sum_d;
      end
   end

   logic [SUM_W-1:0] unused_width_probe;
   assign unused_width_probe = sum_q;

endmodule

// File: rtl/am_thr_regs.sv
module am_thr_regs
   import am_slicer_pkg::*;
#(
   parameter int               ADR_W   = 4,
   parameter int               DAT_W   = 32,
   parameter int               THR_W   = 8,
   parameter logic [THR_W-1:0] THR_RST = 8'h40
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cyc,
   input  logic               stb,
   input  logic               we,
   input  logic [ADR_W-1:0]   adr,
   input  logic [DAT_W/8-1:0] sel,
   input  logic [DAT_W-1:0]   dat_i,
   output logic [DAT_W-1:0]   dat_o,
   output logic               ack,
   output logic [THR_W-1:0]   thr
);

   localparam int SEL_W = DAT_W / 8;

   bus_req_t req;

   always_comb begin
      req.take  = cyc && stb && !ack;
      req.hit   = (adr == '0);
      req.write = req.take && req.hit && we && sel[0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ack   <= 1'b0;
         dat_o <= '0;
         thr   <= THR_RST;
      end else begin
         ack <= req.take;
         if (req.take)
            dat_o <= req.hit ? {{(DAT_W-THR_W){1'b0}}, thr} : '0;
         if (req.write)
            thr <= dat_i[THR_W-1:0];
      end
   end

   logic unused_bus_bits;
   assign unused_bus_bits = ^{dat_i[DAT_W-1:THR_W], sel[SEL_W-1:1]};

endmodule

// File: rtl/am_env_slicer.sv
module am_env_slicer #(
   parameter int                  SAMPLE_W  = 8,
   parameter int                  WIN_LOG2  = 3,
   parameter bit                  SIGNED_IN = 1'b1,
   parameter int                  WB_ADR_W  = 4,
   parameter int                  WB_DAT_W  = 32,
   parameter logic [SAMPLE_W-1:0] THR_RESET = 8'h40
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  samp_valid,
   input  logic [SAMPLE_W-1:0]   samp_data,
   input  logic                  wb_cyc_i,
   input  logic                  wb_stb_i,
   input  logic                  wb_we_i,
   input  logic [WB_ADR_W-1:0]   wb_adr_i,
   input  logic [WB_DAT_W/8-1:0] wb_sel_i,
   input  logic [WB_DAT_W-1:0]   wb_dat_i,
   output logic [WB_DAT_W-1:0]   wb_dat_o,
   output logic                  wb_ack_o,
   output logic                  bit_out,
   output logic                  bit_valid
);

   localparam int SUM_W = SAMPLE_W + WIN_LOG2;

   // Elaboration-time parameter checks
   generate
      if (SAMPLE_W < 2) begin : g_bad_sample_w
         $error("SAMPLE_W must be at least 2");
      end
      if (WIN_LOG2 < 1 || WIN_LOG2 > 6) begin : g_bad_window
         $error("WIN_LOG2 must lie in 1..6");
      end
      if (WB_DAT_W % 8 != 0 || WB_DAT_W < 16) begin : g_bad_bus_w
         $error("WB_DAT_W must be a multiple of 8 and at least 16");
      end
      if (WB_DAT_W <= SAMPLE_W) begin : g_bad_thr_fit
         $error("threshold must fit below the top of the bus word");
      end
   endgenerate

   logic [SAMPLE_W-1:0] mag;
   logic [SUM_W-1:0]    win_sum;
   logic [SUM_W-1:0]    win_sum_d;
   logic [SAMPLE_W-1:0] thr_q;
   logic [SAMPLE_W-1:0] avg_d;

   am_rectify #(
      .W         (SAMPLE_W),
      .SIGNED_IN (SIGNED_IN)
   ) u_rect (
      .raw (samp_data),
      .mag (mag)
   );

   am_window_avg #(
      .W        (SAMPLE_W),
      .LOG2_LEN (WIN_LOG2)
   ) u_win (
      .clk   (clk),
      .rst   (rst),
      .push  (samp_valid),
      .din   (mag),
      .sum_q (win_sum),
      .sum_d (win_sum_d)
   );

   am_thr_regs #(
      .ADR_W   (WB_ADR_W),
      .DAT_W   (WB_DAT_W),
      .THR_W   (SAMPLE_W),
      .THR_RST (THR_RESET)
   ) u_regs (
      .clk   (clk),
      .rst   (rst),
      .cyc   (wb_cyc_i),
      .stb   (wb_stb_i),
      .we    (wb_we_i),
      .adr   (wb_adr_i),
      .sel   (wb_sel_i),
      .dat_i (wb_dat_i),
      .dat_o (wb_dat_o),
      .ack   (wb_ack_o),
      .thr   (thr_q)
   );

   // Average of the window after this sample: divide by the length with a shift
   assign avg_d = win_sum_d[SUM_W-1:WIN_LOG2];

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_out   <= 1'b0;
         bit_valid <= 1'b0;
      end else if (samp_valid) begin
         bit_out   <= (avg_d > thr_q);
         bit_valid <= 1'b1;
      end
   end

   logic unused_frac;
   assign unused_frac = ^{win_sum_d[WIN_LOG2-1:0], win_sum};

endmodule

// File: rtl/am_env_slicer_chk.sv
module am_env_slicer_chk
   import am_slicer_pkg::*;
#(
   parameter int SAMPLE_W  = 8,
   parameter int WIN_LOG2  = 3,
   parameter bit SIGNED_IN = 1'b1,
   parameter int WB_ADR_W  = 4,
   parameter int WB_DAT_W  = 32
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  samp_valid,
   input logic                  bit_out,
   input logic                  bit_valid,
   input logic                  cyc,
   input logic                  stb,
   input logic                  we,
   input logic [WB_ADR_W-1:0]   adr,
   input logic [WB_DAT_W/8-1:0] sel,
   input logic [WB_DAT_W-1:0]   dat_i,
   input logic [WB_DAT_W-1:0]   dat_o,
   input logic                  ack,
   input logic [SAMPLE_W-1:0]   thr,
   input logic [SAMPLE_W+WIN_LOG2-1:0] sum
);

   localparam int SUM_W   = SAMPLE_W + WIN_LOG2;
   localparam int SUM_MAX = (1 << WIN_LOG2) * int'(max_mag(SAMPLE_W, SIGNED_IN));

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
      int'(sum) <= SUM_MAX);

   assert_decide_R4: assert property (@(posedge clk) disable iff (rst)
      samp_valid |=> bit_out == ((sum >> WIN_LOG2) > SUM_W'($past(thr))));

   assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !samp_valid |=> $stable(bit_out) && $stable(bit_valid) && $stable(sum));

   assert_valid_flag_R6: assert property (@(posedge clk) disable iff (rst)
      samp_valid |=> bit_valid);

   assert_ack_cause_R7: assert property (@(posedge clk) disable iff (rst)
      ack |-> $past(cyc && stb));

   assert_ack_prompt_R7: assert property (@(posedge clk) disable iff (rst)
      (cyc && stb && !ack) |=> ack);

   assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      ack |=> !ack);

   assert_read_R8: assert property (@(posedge clk) disable iff (rst)
      (ack && $past(!we && adr == '0)) |-> dat_o == WB_DAT_W'($past(thr)));

   assert_write_R8: assert property (@(posedge clk) disable iff (rst)
      (ack && $past(we && adr == '0 && sel[0])) |-> thr == $past(dat_i[SAMPLE_W-1:0]));

   assert_other_R9: assert property (@(posedge clk) disable iff (rst)
      (ack && $past(adr != '0)) |-> ($stable(thr) && dat_o == '0));

endmodule

bind am_env_slicer am_env_slicer_chk #(
   .SAMPLE_W  (SAMPLE_W),
   .WIN_LOG2  (WIN_LOG2),
   .SIGNED_IN (SIGNED_IN),
   .WB_ADR_W  (WB_ADR_W),
   .WB_DAT_W  (WB_DAT_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .samp_valid (samp_valid),
   .bit_out    (bit_out),
   .bit_valid  (bit_valid),
   .cyc        (wb_cyc_i),
   .stb        (wb_stb_i),
   .we         (wb_we_i),
   .adr        (wb_adr_i),
   .sel        (wb_sel_i),
   .dat_i      (wb_dat_i),
   .dat_o      (wb_dat_o),
   .ack        (wb_ack_o),
   .thr        (thr_q),
   .sum        (win_sum)
);

// File: tb/am_env_slicer_test.sv
module am_env_slicer_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        samp_valid = 1'b0;
   logic [7:0]  samp_data = '0;
   logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
   logic [3:0]  adr = '0;
   logic [3:0]  sel = '0;
   logic [31:0] wdat = '0;
   logic [31:0] rdat;
   logic        ack, bit_out, bit_valid;

   int vectors = 0;
   int errors  = 0;

   always #5 clk = ~clk;

   am_env_slicer uut (
      .clk        (clk),
      .rst        (rst),
      .samp_valid (samp_valid),
      .samp_data  (samp_data),
      .wb_cyc_i   (cyc),
      .wb_stb_i   (stb),
      .wb_we_i    (we),
      .wb_adr_i   (adr),
      .wb_sel_i   (sel),
      .wb_dat_i   (wdat),
      .wb_dat_o   (rdat),
      .wb_ack_o   (ack),
      .bit_out    (bit_out),
      .bit_valid  (bit_valid)
   );

   // ---------------- behavioural reference ----------------
   int win[$];
   int m_sum, m_thr, m_thr_old, m_bit, m_vld, m_ack, m_dat, m_mag;

   function automatic int magof(logic [7:0] d);
      int s;
      s = int'($signed(d));
      if (s == -128) return 127;   // R2 saturation
      return (s < 0) ? -s : s;
   endfunction

   task automatic model_reset();
      win.delete();
      for (int i = 0; i < 8; i++) win.push_back(0);
      m_sum = 0; m_thr = 64; m_bit = 0; m_vld = 0; m_ack = 0; m_dat = 0;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (rst) begin
         model_reset();
      end else begin
         m_thr_old = m_thr;
         if (cyc && stb && !m_ack) begin
            m_ack = 1;
            m_dat = (adr == 4'd0) ? m_thr : 0;
            if (we && adr == 4'd0 && sel[0]) m_thr = int'(wdat[7:0]);
         end else begin
            m_ack = 0;
         end
         if (samp_valid) begin
            m_mag = magof(samp_data);
            win.push_front(m_mag);
            m_sum = m_sum + m_mag - win.pop_back();
            m_bit = ((m_sum / 8) > m_thr_old) ? 1 : 0;
            m_vld = 1;
         end
      end
   end

   task automatic chk(string req, int act, int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Compare every output on every falling edge
   always @(negedge clk) begin
      if (!rst) begin
         chk("R4 bit_out", int'(bit_out), m_bit);
         chk("R6 bit_valid", int'(bit_valid), m_vld);
         chk("R7 ack", int'(ack), m_ack);
         if (m_ack == 1) chk("R8 read data", int'(rdat), m_dat);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(negedge clk);
   endtask

   task automatic push(int v);
      samp_valid = 1'b1;
      samp_data  = v[7:0];
      tick();
      samp_valid = 1'b0;
   endtask

   task automatic wb_access(bit w, int a, int d, logic [3:0] s, output int rd);
      cyc = 1'b1; stb = 1'b1; we = w; adr = a[3:0]; wdat = d; sel = s;
      tick();
      chk("R7 ack one clock after request", int'(ack), 1);
      rd = int'(rdat);
      cyc = 1'b0; stb = 1'b0; we = 1'b0;
      tick();
      chk("R7 ack lasts one cycle", int'(ack), 0);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin : main
      int rd;
      @(negedge clk);
      repeat (3) tick();
      rst = 1'b0;
      // R1: reset state
      chk("R1 bit_out after reset", int'(bit_out), 0);
      chk("R1 bit_valid after reset", int'(bit_valid), 0);
      wb_access(1'b0, 0, 0, 4'hF, rd);
      chk("R1 threshold reset value", rd, 64);

      // R2: most negative sample saturates to 127
      wb_access(1'b1, 0, 126, 4'h1, rd);
      push(-128);
      chk("R6 valid after first sample", int'(bit_valid), 1);
      repeat (7) push(-128);
      chk("R2 -128 rectified to 127 beats 126", int'(bit_out), 1);
      repeat (8) push(127);
      chk("R2 positive full scale", int'(bit_out), 1);
      wb_access(1'b1, 0, 127, 4'h1, rd);
      push(127);
      chk("R4 equal average gives 0", int'(bit_out), 0);

      // R3: floor of sum/8
      wb_access(1'b1, 0, 10, 4'h1, rd);
      push(-10);
      repeat (7) push(11);
      chk("R3 sum 87 floors to 10", int'(bit_out), 0);
      push(11);
      chk("R3 oldest drops out, sum 88", int'(bit_out), 1);

      // R5: samples with valid low are ignored
      samp_data = 8'd0;
      repeat (5) tick();
      chk("R5 bit_out held", int'(bit_out), 1);
      chk("R6 bit_valid held", int'(bit_valid), 1);
      push(11);
      chk("R5 ignored zeros never entered window", int'(bit_out), 1);

      // R8 / R9: byte select and address decode
      wb_access(1'b1, 0, 5, 4'hE, rd);
      wb_access(1'b0, 0, 0, 4'hF, rd);
      chk("R8 write without byte 0 ignored", rd, 10);
      wb_access(1'b1, 3, 200, 4'hF, rd);
      wb_access(1'b0, 0, 0, 4'hF, rd);
      chk("R9 other offset write ignored", rd, 10);
      wb_access(1'b0, 3, 0, 4'hF, rd);
      chk("R9 other offset reads zero", rd, 0);
      wb_access(1'b1, 0, 32'hABCD_EF37, 4'h1, rd);
      wb_access(1'b0, 0, 0, 4'h1, rd);
      chk("R8 write loads low byte", rd, 'h37);

      // Random envelope traffic with mid-stream threshold writes
      for (int n = 0; n < 6000; n++) begin
         int amp, v, sym;
         sym = (n / 400) % 2;
         amp = sym ? 100 : 20;
         v   = (n % 2 == 0) ? amp : -amp;
         v   = v + int'($urandom_range(0, 8)) - 4;
         if (n % 97 == 0) v = -128;
         samp_valid = ($urandom_range(0, 3) != 0);
         samp_data  = v[7:0];
         if (n % 500 == 250) begin
            wb_access(1'b1, 0, int'($urandom_range(20, 90)), 4'h1, rd);
         end else begin
            tick();
         end
      end
      samp_valid = 1'b0;
      tick();
      finish_run();
   end

endmodule